// File: doc/BRIEF.md
# Base Address Region Mapping Scanner

This block decides where each address window of one bus function currently sits. Software sets the function's six base registers, an optional expansion-ROM register and the command word, then pulses `remap_req`. The block then walks the regions in index order, one region per clock. For each implemented region it computes either an effective base address or "not mapped", and records the result.

Whenever a region's recorded mapping changes, the block emits events in the same cycle. A release event carries the old window, if the old window was live. A claim event carries the new window, if the new window is live. The consumer applies the release before the claim. Routing the windows into an address space is left to that consumer.

Region index `NUM_BARS` is the ROM slot when `HAS_ROM` is set. Indices below it are the base registers.

Top module: `bar_map_scan`

## Requirements
- R1: A sampled `remap_req` sets `busy` on the next cycle. `busy` then stays high for exactly NREG cycles, during which regions 0..NREG-1 are evaluated in ascending order, one per cycle. While idle, recorded mappings do not change and no events appear.
- R2: A region whose size input is zero is skipped. It produces no event and stays unmapped (`map_valid` 0).
- R3: An I/O region (its `io_type` bit is 1) can be mapped only when `cmd_word` bit 0 is 1. A memory region, including the ROM slot, can be mapped only when `cmd_word` bit 1 is 1.
- R4: The candidate base is the register value with its low log2(size) bits cleared. The window's last address is candidate + size - 1, computed modulo 2^32.
- R5: An I/O window is rejected if any of these holds: the candidate is 0, the last address is not above the candidate, or the last address is 0x10000 or higher.
- R6: A memory window is rejected if any of these holds: the candidate is 0, the last address is not above the candidate, or the last address is 0xFFFFFFFF.
- R7: The ROM slot is unmapped whenever bit 0 of its register is 0, even with memory decoding on.
- R8: Events are produced only when the new mapping (valid flag, and base when valid) differs from the recorded one. In that cycle `unmap_ev` is high if the old mapping was valid, carrying the old base and size. `map_ev` is high if the new one is valid, carrying the new base and size. Both carry the same region index.
- R9: When an I/O region of size 4 is released while `class_code` equals 0x0101, the release covers only one byte, at old base + 2.
- R10: A `remap_req` that arrives while `busy` is high abandons the current scan. No region is evaluated in that cycle, and a full scan restarts from region 0.
- R11: After reset every region is unmapped (`map_valid` all 0, `map_base` 0), `busy` is low and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| remap_req | input | 1 | Single-cycle request to rescan all regions |
| cmd_word | input | 16 | Command word; bit 0 enables I/O decoding, bit 1 enables memory decoding |
| class_code | input | 16 | Function class code, checked for the narrow-release case |
| reg_vals | input | NREG*AW | Current register value per region, region r at bits r*AW |
| reg_sizes | input | NREG*AW | Window size per region (power of two, 0 = not implemented) |
| io_type | input | NUM_BARS | Per base register, 1 = I/O window, 0 = memory window |
| map_base | output | NREG*AW | Recorded base per region (0 when unmapped) |
| map_valid | output | NREG | Recorded mapped flag per region |
| busy | output | 1 | Scan in progress |
| unmap_ev | output | 1 | Release event for an old window |
| unmap_idx | output | IDXW | Region index of the release |
| unmap_addr | output | AW | First address released |
| unmap_len | output | AW | Number of addresses released |
| map_ev | output | 1 | Claim event for a new window |
| map_idx | output | IDXW | Region index of the claim |
| map_addr | output | AW | First address claimed |
| map_len | output | AW | Number of addresses claimed |

## Verification
On every cycle the assertions check the scan handshake and the event discipline. They confirm that a request leads to `busy`, that events appear only while a scan was running, that a paired release and claim name one region, that a claimed window never starts at 0 or has zero length, and that nothing moves while the block is idle.

The address arithmetic can only be shown by the scenarios, run against a scoreboard model: masking, the I/O 64K ceiling, the all-ones memory limit, the ROM enable bit, the one-byte release for the 0x0101 class, and the restart of an abandoned scan. These need specific register values and a history of earlier mappings.

// File: rtl/bms_pkg.sv
package bms_pkg;
   localparam int CMD_IO_BIT   = 0;
   localparam int CMD_MEM_BIT  = 1;
   localparam int ROM_EN_BIT   = 0;
   localparam logic [15:0] NARROW_CLASS = 16'h0101;
   localparam int NARROW_SIZE  = 4;
   localparam int NARROW_OFS   = 2;
endpackage

// File: rtl/bms_scan_ctl.sv
module bms_scan_ctl #(
   parameter int NREG = 7,
   parameter int IDXW = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   output logic            busy,
   output logic [IDXW-1:0] idx,
   output logic            step
);
   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NREG - 1);

   assign step = busy && !req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (req) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy) begin
         if (idx == LAST_IDX) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bms_region_eval.sv
module bms_region_eval
   import bms_pkg::*;
#(
   parameter int          AW       = 32,
   parameter int unsigned IO_LIMIT = 32'h0001_0000
) (
   input  logic [AW-1:0] val,
   input  logic [AW-1:0] size,
   input  logic          is_io,
   input  logic          is_rom,
   input  logic          io_en,
   input  logic          mem_en,
   output logic          valid,
   output logic [AW-1:0] base
);
   logic [AW-1:0] cand;
   logic [AW-1:0] last;
   logic          enabled;
   logic          bad_common;
   logic          bad_io;
   logic          bad_mem;

   always_comb begin
      cand       = val & ~(size - 1'b1);
      last       = cand + size - 1'b1;
      enabled    = is_io ? io_en : (mem_en && (!is_rom || val[ROM_EN_BIT]));
      bad_common = (last <= cand) || (cand == '0);
      bad_io     = (last >= AW'(IO_LIMIT));
      bad_mem    = &last;
      valid      = enabled && !bad_common && !(is_io ? bad_io : bad_mem);
      base       = cand;
   end
endmodule

// File: rtl/bar_map_scan.sv
module bar_map_scan
   import bms_pkg::*;
#(
   parameter int          NUM_BARS = 6,
   parameter bit          HAS_ROM  = 1'b1,
   parameter int          AW       = 32,
   parameter int unsigned IO_LIMIT = 32'h0001_0000,
   localparam int NREG = NUM_BARS + (HAS_ROM ? 1 : 0),
   localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               remap_req,
   input  logic [15:0]        cmd_word,
   input  logic [15:0]        class_code,
   input  logic [NREG*AW-1:0] reg_vals,
   input  logic [NREG*AW-1:0] reg_sizes,
   input  logic [NUM_BARS-1:0] io_type,
   output logic [NREG*AW-1:0] map_base,
   output logic [NREG-1:0]    map_valid,
   output logic               busy,
   output logic               unmap_ev,
   output logic [IDXW-1:0]    unmap_idx,
   output logic [AW-1:0]      unmap_addr,
   output logic [AW-1:0]      unmap_len,
   output logic               map_ev,
   output logic [IDXW-1:0]    map_idx,
   output logic [AW-1:0]      map_addr,
   output logic [AW-1:0]      map_len
);
   if (NUM_BARS < 1) begin : g_bad_bars
      $error("bar_map_scan: NUM_BARS must be at least 1");
   end
   if (AW < 17) begin : g_bad_aw
      $error("bar_map_scan: AW must hold the I/O limit");
   end

   logic [AW-1:0] val_a  [NREG];
   logic [AW-1:0] size_a [NREG];
   logic          io_a   [NREG];
   logic          rom_a  [NREG];
   logic [AW-1:0] base_q [NREG];
   logic [NREG-1:0] valid_q;

   for (genvar r = 0; r < NREG; r++) begin : g_slot
      assign val_a[r]  = reg_vals [r*AW +: AW];
      assign size_a[r] = reg_sizes[r*AW +: AW];
      assign map_base[r*AW +: AW] = base_q[r];
      if (r < NUM_BARS) begin : g_bar
         assign io_a[r]  = io_type[r];
         assign rom_a[r] = 1'b0;
      end else begin : g_rom
         assign io_a[r]  = 1'b0;
         assign rom_a[r] = 1'b1;
      end
   end
   assign map_valid = valid_q;

   logic [IDXW-1:0] idx;
   logic            step;

   bms_scan_ctl #(.NREG(NREG), .IDXW(IDXW)) u_ctl (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (remap_req),
      .busy (busy),
      .idx  (idx),
      .step (step)
   );

   logic [AW-1:0] cur_val, cur_size, old_base, new_base;
   logic          cur_io, cur_rom, old_valid, new_valid;
   logic          changed, narrow;

   always_comb begin
      cur_val   = val_a[idx];
      cur_size  = size_a[idx];
      cur_io    = io_a[idx];
      cur_rom   = rom_a[idx];
      old_base  = base_q[idx];
      old_valid = valid_q[idx];
   end

   bms_region_eval #(.AW(AW), .IO_LIMIT(IO_LIMIT)) u_eval (
      .val   (cur_val),
      .size  (cur_size),
      .is_io (cur_io),
      .is_rom(cur_rom),
      .io_en (cmd_word[CMD_IO_BIT]),
      .mem_en(cmd_word[CMD_MEM_BIT]),
      .valid (new_valid),
      .base  (new_base)
   );

   always_comb begin
      changed = (new_valid != old_valid) || (new_valid && (new_base != old_base));
      narrow  = cur_io && (cur_size == AW'(NARROW_SIZE)) && (class_code == NARROW_CLASS);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREG; r++) base_q[r] <= '0;
         valid_q    <= '0;
         unmap_ev   <= 1'b0;
         unmap_idx  <= '0;
         unmap_addr <= '0;
         unmap_len  <= '0;
         map_ev     <= 1'b0;
         map_idx    <= '0;
         map_addr   <= '0;
         map_len    <= '0;
      end else begin
         unmap_ev <= 1'b0;
         map_ev   <= 1'b0;
         if (step && (cur_size != '0) && changed) begin
            unmap_ev   <= old_valid;
            unmap_idx  <= idx;
            unmap_addr <= narrow ? old_base + AW'(NARROW_OFS) : old_base;
            unmap_len  <= narrow ? AW'(1) : cur_size;
            map_ev     <= new_valid;
            map_idx    <= idx;
            map_addr   <= new_base;
            map_len    <= cur_size;
            base_q[idx]  <= new_valid ? new_base : '0;
            valid_q[idx] <= new_valid;
         end
      end
   end
endmodule

// File: rtl/bar_map_scan_chk.sv
module bar_map_scan_chk #(
   parameter int NREG = 7,
   parameter int IDXW = 3,
   parameter int AW   = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            remap_req,
   input logic            busy,
   input logic            unmap_ev,
   input logic [IDXW-1:0] unmap_idx,
   input logic            map_ev,
   input logic [IDXW-1:0] map_idx,
   input logic [AW-1:0]   map_addr,
   input logic [AW-1:0]   map_len,
   input logic [NREG-1:0] map_valid
);
   // R1
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      remap_req |=> busy);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !remap_req) |=> ($stable(map_valid) && !unmap_ev && !map_ev));

   // R8
   ev_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unmap_ev || map_ev) |-> $past(busy));

   // R8
   pair_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (unmap_ev && map_ev) |-> (unmap_idx == map_idx));

   // R5
   map_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      map_ev |-> (map_addr != '0));

   // R2
   map_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      map_ev |-> (map_len != '0));
endmodule

bind bar_map_scan bar_map_scan_chk #(.NREG(NREG), .IDXW(IDXW), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .remap_req(remap_req),
   .busy     (busy),
   .unmap_ev (unmap_ev),
   .unmap_idx(unmap_idx),
   .map_ev   (map_ev),
   .map_idx  (map_idx),
   .map_addr (map_addr),
   .map_len  (map_len),
   .map_valid(map_valid)
);

// File: tb/bar_map_scan_tb.sv
`timescale 1ns/1ps
module bar_map_scan_tb;
   localparam int NB = 6;
   localparam int NR = 7;
   localparam int AW = 32;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic remap_req = 1'b0;
   logic [15:0] cmd_word = '0;
   logic [15:0] class_code = '0;
   logic [31:0] vals [NR];
   logic [31:0] sizes [NR];
   logic [NB-1:0] io_type = '0;
   logic [NR*AW-1:0] reg_vals, reg_sizes, map_base;
   logic [NR-1:0] map_valid;
   logic busy, unmap_ev, map_ev;
   logic [IW-1:0] unmap_idx, map_idx;
   logic [AW-1:0] unmap_addr, unmap_len, map_addr, map_len;

   always #2 clk = ~clk;

   always_comb begin
      for (int i = 0; i < NR; i++) begin
         reg_vals [i*AW +: AW] = vals[i];
         reg_sizes[i*AW +: AW] = sizes[i];
      end
   end

   bar_map_scan u_dut (
      .clk(clk), .rst_n(rst_n), .remap_req(remap_req), .cmd_word(cmd_word),
      .class_code(class_code), .reg_vals(reg_vals), .reg_sizes(reg_sizes),
      .io_type(io_type), .map_base(map_base), .map_valid(map_valid), .busy(busy),
      .unmap_ev(unmap_ev), .unmap_idx(unmap_idx), .unmap_addr(unmap_addr),
      .unmap_len(unmap_len), .map_ev(map_ev), .map_idx(map_idx),
      .map_addr(map_addr), .map_len(map_len)
   );

   typedef struct {
      bit u; int unsigned ui; logic [31:0] ua; logic [31:0] ul;
      bit m; int unsigned mi; logic [31:0] ma; logic [31:0] ml;
   } ev_t;
   ev_t exp_q[$];

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit          mv [NR];
   logic [31:0] mb [NR];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // scoreboard model of one region evaluation (R2..R9)
   task automatic model_region(input int i);
      bit io, rom, en, ok, nar;
      logic [31:0] c32;
      longint unsigned last;
      ev_t e;
      io  = (i < NB) ? io_type[i] : 1'b0;
      rom = (i == NB);
      if (sizes[i] == 0) return;                       // R2
      c32  = vals[i] & ~(sizes[i] - 32'd1);            // R4
      last = longint'(c32) + longint'(sizes[i]) - 1;
      en   = io ? cmd_word[0] : (cmd_word[1] && (!rom || vals[i][0]));  // R3 R7
      ok   = en && (last > longint'(c32)) && (c32 != 0) &&
             (io ? (last < 64'h10000) : (last < 64'hFFFF_FFFF));        // R5 R6
      if (ok != mv[i] || (ok && c32 != mb[i])) begin   // R8
         nar  = io && sizes[i] == 4 && class_code == 16'h0101;          // R9
         e.u  = mv[i]; e.ui = i;
         e.ua = nar ? mb[i] + 32'd2 : mb[i];
         e.ul = nar ? 32'd1 : sizes[i];
         e.m  = ok; e.mi = i; e.ma = c32; e.ml = sizes[i];
         exp_q.push_back(e);
         mv[i] = ok;
         mb[i] = ok ? c32 : 32'd0;
      end
   endtask

   // monitor: compare every event cycle with the next expected item
   always @(negedge clk) begin
      if (rst_n && (unmap_ev || map_ev)) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected event", {unmap_ev, map_ev}, 0);
         end else begin
            ev_t e;
            e = exp_q.pop_front();
            check(unmap_ev == e.u, "R8", "release flag", unmap_ev, e.u);
            if (e.u) begin
               check(unmap_idx == e.ui[IW-1:0], "R1", "release index", unmap_idx, e.ui);
               check(unmap_addr == e.ua && unmap_len == e.ul, "R9", "release window",
                     {unmap_addr, unmap_len}, {e.ua, e.ul});
            end
            check(map_ev == e.m, "R8", "claim flag", map_ev, e.m);
            if (e.m) begin
               check(map_idx == e.mi[IW-1:0], "R1", "claim index", map_idx, e.mi);
               check(map_addr == e.ma && map_len == e.ml, "R4", "claim window",
                     {map_addr, map_len}, {e.ma, e.ml});
            end
         end
      end
   end

   task automatic count_busy();
      int cnt = 0;
      check(busy == 1'b1, "R1", "busy after request", busy, 1);
      while (busy && cnt < 50) begin
         cnt++;
         @(negedge clk);
      end
      check(cnt == NR, "R1", "busy length", cnt, NR);
      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R8", "expected events left", exp_q.size(), 0);
      for (int i = 0; i < NR; i++) begin
         check(map_valid[i] == mv[i] && map_base[i*AW +: AW] == mb[i], "R4",
               $sformatf("region %0d state", i),
               {map_valid[i], map_base[i*AW +: AW]}, {mv[i], mb[i]});
      end
   endtask

   task automatic run_scan();
      for (int i = 0; i < NR; i++) model_region(i);
      @(negedge clk); remap_req = 1'b1;
      @(negedge clk); remap_req = 1'b0;
      count_busy();
   endtask

   task automatic run_restart();
      model_region(0);
      model_region(1);
      for (int i = 0; i < NR; i++) model_region(i);
      @(negedge clk); remap_req = 1'b1;
      @(negedge clk); remap_req = 1'b0;
      @(negedge clk);
      @(negedge clk); remap_req = 1'b1;   // R10 restart mid-scan
      @(negedge clk); remap_req = 1'b0;
      count_busy();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NR; i++) begin
         vals[i] = '0; sizes[i] = '0; mv[i] = 0; mb[i] = '0;
      end
      sizes[0] = 32'h10;   io_type[0] = 1'b1;
      sizes[1] = 32'h1000;
      sizes[2] = 32'h0;
      sizes[3] = 32'h4;    io_type[3] = 1'b1;
      sizes[4] = 32'h100;
      sizes[5] = 32'h10;
      sizes[6] = 32'h800;
      repeat (3) @(negedge clk);
      // R11 reset state
      check(map_valid == '0 && map_base == '0, "R11", "reset state", map_valid, 0);
      check(!busy && !unmap_ev && !map_ev, "R11", "reset flags", {busy, unmap_ev, map_ev}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // decoding off: nothing maps (R3)
      vals[0] = 32'h1001; vals[1] = 32'hE000_1234; vals[3] = 32'h1F4;
      vals[4] = 32'h0;    vals[5] = 32'hFFFF_FFF0; vals[6] = 32'hC000_0801;
      run_scan();
      check(map_valid == 7'b0, "R3", "decoding off", map_valid, 0);

      // both enabled: zero base, top-of-space reject (R5 R6 R7)
      cmd_word = 16'h0003;
      run_scan();
      check(map_valid == 7'b1001011, "R6", "valid pattern", map_valid, 7'b1001011);
      check(map_base[1*AW +: AW] == 32'hE000_1000, "R4", "masked base", map_base[1*AW +: AW], 32'hE000_1000);

      // narrow release, ROM disable, I/O near top of 64K still fine (R9 R7 R5)
      class_code = 16'h0101;
      vals[3] = 32'h3F4; vals[0] = 32'hFFF8; vals[6] = 32'hC000_0800; vals[4] = 32'h2000_0000;
      run_scan();
      check(map_valid[6] == 1'b0, "R7", "ROM enable bit", map_valid[6], 0);
      check(map_valid[0] == 1'b1, "R5", "I/O at FFF0", map_valid[0], 1);

      // I/O beyond 64K, I/O decoding off (R5 R3 R9)
      vals[0] = 32'h1FFF0;
      run_scan();
      cmd_word = 16'h0002;
      run_scan();
      check(map_valid[3] == 1'b0 && map_valid[4] == 1'b1, "R3", "I/O off, memory on",
            map_valid, 7'b0010010);

      // unchanged rescan: no events (R8), restart (R10)
      run_scan();
      cmd_word = 16'h0003; vals[0] = 32'h2000; vals[6] = 32'hC000_1001;
      run_restart();
      check(map_valid[2] == 1'b0, "R2", "unimplemented region", map_valid[2], 0);

      // memory off (R3)
      cmd_word = 16'h0001;
      run_scan();
      check(map_valid == 7'b0001001, "R3", "memory off", map_valid, 7'b0001001);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule